// File: doc/BRIEF.md
# Motor Driver Fault Supervisor

This block decides whether the power stages of a dual H-bridge driver may switch. Its inputs are a sleep request, a logic-supply undervoltage flag, low-voltage flags for the charge pump and the gate regulator, and an 8-bit junction temperature code in whole degrees Celsius. Its outputs are one drive-enable signal and a five-bit status vector. Every input is already synchronous to the block clock.

Each voltage flag passes through a stability filter before the block acts on it. Temperature is compared against a trip threshold and a lower release threshold, which gives hysteresis. No fault is latched. The driver switches again on its own once every filtered condition is clear.

Sleep takes priority over everything else. While it is requested, all monitors are parked, including the supply monitor. On wake the supervisor starts again in lockout, so the supply has to be confirmed good before the drivers switch.

Top module: `mfs_supervisor`

## Requirements
- R1: While reset is active and on the first cycle after it, `drive_en` is 0 and `fault_status` is 5'b00001 (only the lockout bit set).
- R2: Status bit 0 is supply lockout. It is set out of reset, and `drive_en` stays 0 for as long as it is set.
- R3: A change on `uv_flag`, `cp_low` or `reg_low` is taken into the filtered state only after the new level has been sampled on STABLE_CYCLES consecutive clock edges (default 4). This holds for both rising and falling changes. A shorter excursion leaves the filtered bit unchanged.
- R4: Status bit 1 (charge pump low) and status bit 2 (regulator low) each hold `drive_en` at 0 while set. Each bit clears by itself once its flag has been stable low for the filter time.
- R5: Status bit 3 (over-temperature) is set one clock after an edge that samples `temp_code` >= TEMP_TRIP (default 165) while sleep is not requested.
- R6: Status bit 3 clears one clock after an edge that samples `temp_code` <= TEMP_RELEASE (default 150). A code strictly between the two thresholds keeps the previous state.
- R7: An edge that samples `sleep_req` high sets status bit 4 and bit 0 and clears bits 1 to 3 and all filter counts. During sleep every other input has no effect.
- R8: After `sleep_req` falls, `drive_en` stays 0 until `uv_flag` has been seen low on STABLE_CYCLES consecutive edges, counted from the first edge that samples `sleep_req` low.
- R9: `drive_en` is 1 exactly when all five status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| sleep_req | input | 1 | Low-power request; parks all monitors |
| uv_flag | input | 1 | Logic supply below threshold |
| cp_low | input | 1 | Charge pump voltage low |
| reg_low | input | 1 | Gate regulator voltage low |
| temp_code | input | 8 | Junction temperature, unsigned degrees Celsius |
| drive_en | output | 1 | Bridge outputs may switch |
| fault_status | output | 5 | {sleep, thermal, reg low, cp low, lockout}, bit 0 = lockout |

## Verification
The critical overlap is a sleep transition landing on the same edge as a filter commit or a thermal trip. Sleep must win on entry. On exit, the thermal comparator acts immediately while the lockout filter starts counting from zero. The random phase toggles sleep while flags are mid-filter and temperature is walking across both thresholds. Directed sequences also release sleep with the temperature above the trip point. Each output bit is compared every cycle against a bench model built from the requirements.

// File: rtl/mfs_pkg.sv
package mfs_pkg;
  // Positions inside the status vector
  localparam int unsigned ST_UV    = 0;
  localparam int unsigned ST_CP    = 1;
  localparam int unsigned ST_REG   = 2;
  localparam int unsigned ST_THERM = 3;
  localparam int unsigned ST_SLEEP = 4;
  localparam int unsigned ST_W     = 5;

  // Number of filtered voltage flags and their parked values
  localparam int unsigned NFLAG = 3;
  localparam logic [NFLAG-1:0] FLAG_PARK = 3'b001;
endpackage

// File: rtl/mfs_deglitch.sv
module mfs_deglitch #(
  parameter int unsigned STABLE_CYCLES = 4,
  parameter logic        PARK_VAL      = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic park,
  input  logic raw,
  output logic filt
);
  localparam int unsigned CW = (STABLE_CYCLES > 1) ? $clog2(STABLE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          filt_q, filt_d;

  // Next state: count edges on which raw disagrees with the filtered level
  always_comb begin
    cnt_d  = cnt_q;
    filt_d = filt_q;
    if (park) begin
      cnt_d  = '0;
      filt_d = PARK_VAL;
    end else if (raw == filt_q) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      cnt_d  = '0;
      filt_d = raw;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= PARK_VAL;
    end else begin
      cnt_q  <= cnt_d;
      filt_q <= filt_d;
    end
  end

  assign filt = filt_q;
endmodule

// File: rtl/mfs_thermal.sv
module mfs_thermal #(
  parameter int unsigned TW           = 8,
  parameter int unsigned TEMP_TRIP    = 165,
  parameter int unsigned TEMP_RELEASE = 150
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          park,
  input  logic [TW-1:0] temp,
  output logic          hot
);
  localparam logic [TW-1:0] TRIP_V = TW'(TEMP_TRIP);
  localparam logic [TW-1:0] REL_V  = TW'(TEMP_RELEASE);

  logic hot_q, hot_d;

  always_comb begin
    hot_d = hot_q;
    if (park)                hot_d = 1'b0;
    else if (temp >= TRIP_V) hot_d = 1'b1;
    else if (temp <= REL_V)  hot_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hot_q <= 1'b0;
    else        hot_q <= hot_d;
  end

  assign hot = hot_q;
endmodule

// File: rtl/mfs_supervisor.sv
module mfs_supervisor
  import mfs_pkg::*;
#(
  parameter int unsigned STABLE_CYCLES = 4,
  parameter int unsigned TEMP_W        = 8,
  parameter int unsigned TEMP_TRIP     = 165,
  parameter int unsigned TEMP_RELEASE  = 150
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic              uv_flag,
  input  logic              cp_low,
  input  logic              reg_low,
  input  logic [TEMP_W-1:0] temp_code,
  output logic              drive_en,
  output logic [ST_W-1:0]   fault_status
);
  logic [NFLAG-1:0] flag_raw, flag_filt;
  logic             hot;
  logic             sleep_q, sleep_d;

  assign flag_raw = {reg_low, cp_low, uv_flag};

  for (genvar g = 0; g < NFLAG; g++) begin : g_flt
    mfs_deglitch #(
      .STABLE_CYCLES(STABLE_CYCLES),
      .PARK_VAL     (FLAG_PARK[g])
    ) u_flt (
      .clk  (clk),
      .rst_n(rst_n),
      .park (sleep_req),
      .raw  (flag_raw[g]),
      .filt (flag_filt[g])
    );
  end

  mfs_thermal #(
    .TW          (TEMP_W),
    .TEMP_TRIP   (TEMP_TRIP),
    .TEMP_RELEASE(TEMP_RELEASE)
  ) u_therm (
    .clk  (clk),
    .rst_n(rst_n),
    .park (sleep_req),
    .temp (temp_code),
    .hot  (hot)
  );

  always_comb sleep_d = sleep_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sleep_q <= 1'b0;
    else        sleep_q <= sleep_d;
  end

  always_comb begin
    fault_status           = '0;
    fault_status[ST_UV]    = flag_filt[0];
    fault_status[ST_CP]    = flag_filt[1];
    fault_status[ST_REG]   = flag_filt[2];
    fault_status[ST_THERM] = hot;
    fault_status[ST_SLEEP] = sleep_q;
  end

  assign drive_en = ~|fault_status;
endmodule

// File: rtl/mfs_supervisor_chk.sv
module mfs_supervisor_chk #(
  parameter int unsigned TEMP_W       = 8,
  parameter int unsigned TEMP_TRIP    = 165,
  parameter int unsigned TEMP_RELEASE = 150
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep_req,
  input logic              cp_low,
  input logic              reg_low,
  input logic [TEMP_W-1:0] temp_code,
  input logic              drive_en,
  input logic [4:0]        fault_status
);
  // R7
  sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> (!drive_en && fault_status[4] && fault_status[0] && fault_status[3:1] == 3'b000));

  // R5
  therm_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_req && temp_code >= TEMP_W'(TEMP_TRIP)) |=> fault_status[3]);

  // R6
  therm_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_code <= TEMP_W'(TEMP_RELEASE)) |=> !fault_status[3]);

  // R6
  therm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_req && temp_code > TEMP_W'(TEMP_RELEASE) && temp_code < TEMP_W'(TEMP_TRIP))
      |=> $stable(fault_status[3]));

  // R3
  cp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_status[1]) |-> ($past(cp_low) && !$past(sleep_req)));

  // R4
  reg_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_status[2]) |-> ($past(sleep_req) || !$past(reg_low)));

  // R9
  drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> (fault_status == 5'b00000));
endmodule

bind mfs_supervisor mfs_supervisor_chk #(
  .TEMP_W      (TEMP_W),
  .TEMP_TRIP   (TEMP_TRIP),
  .TEMP_RELEASE(TEMP_RELEASE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sleep_req   (sleep_req),
  .cp_low      (cp_low),
  .reg_low     (reg_low),
  .temp_code   (temp_code),
  .drive_en    (drive_en),
  .fault_status(fault_status)
);

// File: tb/test_mfs_supervisor.sv
module test_mfs_supervisor;
  localparam int STABLE = 4;
  localparam int TRIP   = 165;
  localparam int REL    = 150;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep_req = 1'b0;
  logic       uv_flag = 1'b0;
  logic       cp_low = 1'b0;
  logic       reg_low = 1'b0;
  logic [7:0] temp_code = 8'd25;
  logic       drive_en;
  logic [4:0] fault_status;

  int n_cmp = 0;
  int n_bad = 0;

  // bench model state
  logic m_f[3];
  int   m_c[3];
  logic m_th, m_sl;

  always #4 clk = ~clk;

  mfs_supervisor i_mfs_supervisor (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .uv_flag(uv_flag),
    .cp_low(cp_low), .reg_low(reg_low), .temp_code(temp_code),
    .drive_en(drive_en), .fault_status(fault_status)
  );

  function automatic logic [4:0] exp_status();
    return {m_sl, m_th, m_f[2], m_f[1], m_f[0]};
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin
      m_f[i] = (i == 0);
      m_c[i] = 0;
    end
    m_th = 1'b0;
    m_sl = 1'b0;
  endtask

  task automatic model_tick();
    logic raw[3];
    raw[0] = uv_flag; raw[1] = cp_low; raw[2] = reg_low;
    if (sleep_req) begin
      for (int i = 0; i < 3; i++) begin
        m_f[i] = (i == 0);
        m_c[i] = 0;
      end
      m_th = 1'b0;
      m_sl = 1'b1;
    end else begin
      m_sl = 1'b0;
      for (int i = 0; i < 3; i++) begin
        if (raw[i] == m_f[i]) m_c[i] = 0;
        else if (m_c[i] == STABLE - 1) begin
          m_f[i] = raw[i];
          m_c[i] = 0;
        end else m_c[i] = m_c[i] + 1;
      end
      if (int'(temp_code) >= TRIP)     m_th = 1'b1;
      else if (int'(temp_code) <= REL) m_th = 1'b0;
    end
  endtask

  task automatic compare_all();
    logic [4:0] e;
    e = exp_status();
    chk("R2 lockout bit", fault_status[0], e[0]);
    chk("R4 cp bit", fault_status[1], e[1]);
    chk("R4 reg bit", fault_status[2], e[2]);
    chk("R5 thermal bit", fault_status[3], e[3]);
    chk("R7 sleep bit", fault_status[4], e[4]);
    chk("R9 drive_en", drive_en, (e == 5'b0));
  endtask

  // one clock: inputs already set at the preceding falling edge
  task automatic cycle();
    @(posedge clk);
    #1;
    if (rst_n) model_tick();
    else       model_reset();
    @(negedge clk);
    compare_all();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int seed;
    int t;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    model_reset();
    @(negedge clk);
    // R1: reset state
    chk("R1 status in reset", fault_status, 5'b00001);
    chk("R1 drive_en in reset", drive_en, 0);
    run(2);
    rst_n = 1'b1;
    cycle();
    chk("R1 status after reset", fault_status, 5'b00001);

    // R8-like: supply good, lockout releases after STABLE edges
    run(STABLE - 2);
    chk("R2 still locked", drive_en, 0);
    cycle();
    chk("R2 lockout released", drive_en, 1);

    // R3: short cp glitch is ignored
    cp_low = 1'b1; run(STABLE - 1);
    cp_low = 1'b0; run(STABLE);
    chk("R3 glitch ignored", fault_status[1], 0);
    // R3/R4: full-length cp fault accepted
    cp_low = 1'b1; run(STABLE);
    chk("R3 cp accepted", fault_status[1], 1);
    chk("R4 cp disables", drive_en, 0);
    cp_low = 1'b0; run(STABLE - 1);
    chk("R3 cp release filtered", fault_status[1], 1);
    cycle();
    chk("R4 cp auto release", drive_en, 1);
    // R4: regulator low
    reg_low = 1'b1; run(STABLE);
    chk("R4 reg disables", drive_en, 0);
    reg_low = 1'b0; run(STABLE);
    chk("R4 reg auto release", drive_en, 1);

    // R5/R6 thresholds
    temp_code = 8'd164; cycle();
    chk("R5 below trip", fault_status[3], 0);
    temp_code = 8'd165; cycle();
    chk("R5 at trip", fault_status[3], 1);
    temp_code = 8'd151; run(3);
    chk("R6 hysteresis hold", fault_status[3], 1);
    temp_code = 8'd150; cycle();
    chk("R6 release", fault_status[3], 0);

    // R7: sleep while hot and cp faulting; inputs ignored
    temp_code = 8'd200; cp_low = 1'b1; sleep_req = 1'b1; run(6);
    chk("R7 sleep status", fault_status, 5'b10001);
    uv_flag = 1'b1; reg_low = 1'b1; run(5);
    chk("R7 inputs ignored", fault_status, 5'b10001);
    // R8: wake with supply good, cool temperature
    uv_flag = 1'b0; reg_low = 1'b0; cp_low = 1'b0; temp_code = 8'd40;
    sleep_req = 1'b0;
    run(STABLE - 1);
    chk("R8 locked after wake", drive_en, 0);
    cycle();
    chk("R8 enabled after wake", drive_en, 1);
    // wake while hot: thermal acts on first edge
    sleep_req = 1'b1; run(2);
    sleep_req = 1'b0; temp_code = 8'd170; cycle();
    chk("R5 trip on wake edge", fault_status[3], 1);
    temp_code = 8'd60; run(STABLE + 1);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 5) == 0)   cp_low    = ~cp_low;
      if ($urandom_range(0, 6) == 0)   reg_low   = ~reg_low;
      if ($urandom_range(0, 19) == 0)  uv_flag   = ~uv_flag;
      if ($urandom_range(0, 149) == 0) sleep_req = ~sleep_req;
      t = int'(temp_code) + int'($urandom_range(0, 6)) - 3;
      if (t < 130) t = 130;
      if (t > 185) t = 185;
      temp_code = 8'(t);
      cycle();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule